// File: doc/BRIEF.md
# Halfword Dual Signed Multiply-Accumulate Unit

This execution unit takes two 32-bit source words, splits each into two signed 16-bit halves, and forms one of sixteen results: a single halfword product (any pairing of top or bottom halves), a single product plus a signed 32-bit accumulator, the sum of two halfword products, or the difference of two halfword products. Each dual form has a straight pairing and an exchanged pairing, and each can take the accumulator or leave it out. The 32-bit result always wraps modulo 2^32. The unit never saturates. When a flag-producing form overflows the signed 32-bit range, it sets a sticky overflow flag in a status word that travels with the operation.

Operations enter on a valid/ready stream and leave on a second valid/ready stream. One output register separates the two. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle on. While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` is low, so back-pressure reaches the producer in the same cycle. When the output register is empty, or is being drained in the same cycle, `in_ready` is high. A producer may drop `in_valid` at any time. A transfer happens only on a cycle where valid and ready are both high.

Top module: `hmac_dual_unit`

## Requirements
- R1: For `in_op` 0 to 3, the result is the product of one sign-extended 16-bit half of A and one of B. `in_op[1]`=1 selects A bits 31:16 (else 15:0) and `in_op[0]`=1 selects B bits 31:16 (else 15:0). The status word passes through unchanged.
- R2: For `in_op` 4 to 7, the halves are chosen as in R1 by `in_op[1:0]`, and the signed accumulator is added to the product. The result wraps modulo 2^32.
- R3: For `in_op` 8 to 11 (the dual-add forms), the result is Atop*Btop + Abot*Bbot. When `in_op[0]`=1 (exchange), it is instead Atop*Bbot + Abot*Btop. The accumulator is added when `in_op[1]`=1.
- R4: For `in_op` 12 to 15 (the dual-subtract forms), the result is Abot*Bbot - Atop*Btop. When `in_op[0]`=1 (exchange), it is Abot*Btop - Atop*Bbot. The accumulator is added when `in_op[1]`=1.
- R5: For `in_op` 4 to 11, status bit 27 is set when the exact signed result lies outside [-2^31, 2^31-1]. Every other status bit is passed through.
- R6: Status bit 27 is never cleared. For `in_op` 0 to 3 and 12 to 15, the output status equals the input status, even when the exact result overflows.
- R7: `out_valid`, `out_result` and `out_status` for an accepted operation appear on the first rising edge after acceptance.
- R8: `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is high and `out_ready` is low, `out_result` and `out_status` stay stable and `out_valid` stays high.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 4 | Operation select (see R1 to R4) |
| in_a | input | 32 | Source word A |
| in_b | input | 32 | Source word B |
| in_acc | input | 32 | Signed accumulator word |
| in_status | input | 32 | Status word carried through; bit 27 is the sticky overflow flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Wrapped 32-bit result |
| out_status | output | 32 | Status word, with bit 27 possibly set |

## Verification
Overflow of a dual-add form without an accumulator is the hardest case to reach from the ports. It happens only when both halfword pairs are -32768 times -32768, which gives exactly 2^31, and uniform random operands essentially never produce it. The stimulus therefore draws each halfword from a short list of extremes (-32768, 32767, -1, 1), with a uniform value mixed in. Directed operations also cover both signs of overflow and dual-subtract overflow, which must leave the flag alone. All of this runs with `out_ready` toggling randomly, so results are also checked while held under back-pressure.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

  // operation encoding: bit3 = dual; single: bit2 acc, bit1 A top, bit0 B top
  // dual: bit2 subtract, bit1 acc, bit0 exchange
  typedef enum logic [3:0] {
    OP_MUL_BB    = 4'd0,
    OP_MUL_BT    = 4'd1,
    OP_MUL_TB    = 4'd2,
    OP_MUL_TT    = 4'd3,
    OP_MAC_BB    = 4'd4,
    OP_MAC_BT    = 4'd5,
    OP_MAC_TB    = 4'd6,
    OP_MAC_TT    = 4'd7,
    OP_DADD      = 4'd8,
    OP_DADDX     = 4'd9,
    OP_DADD_ACC  = 4'd10,
    OP_DADDX_ACC = 4'd11,
    OP_DSUB      = 4'd12,
    OP_DSUBX     = 4'd13,
    OP_DSUB_ACC  = 4'd14,
    OP_DSUBX_ACC = 4'd15
  } hm_op_e;

  typedef struct packed {
    logic a0_top;    // lane 0 takes top half of A
    logic b0_top;    // lane 0 takes top half of B
    logic a1_top;    // lane 1 takes top half of A
    logic b1_top;    // lane 1 takes top half of B
    logic lane1_en;  // second product participates
    logic subtract;  // lane0 - lane1
    logic acc_en;    // accumulator participates
    logic q_en;      // overflow may set sticky flag
  } hm_ctrl_t;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
  import hmac_pkg::*;
(
  input  logic [3:0] op,
  output hm_ctrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    if (!op[3]) begin
      ctrl.a0_top   = op[1];
      ctrl.b0_top   = op[0];
      ctrl.a1_top   = 1'b0;
      ctrl.b1_top   = 1'b0;
      ctrl.lane1_en = 1'b0;
      ctrl.subtract = 1'b0;
      ctrl.acc_en   = op[2];
      ctrl.q_en     = op[2];
    end else begin
      // lane 0 always uses A bottom, lane 1 always A top
      ctrl.a0_top   = 1'b0;
      ctrl.b0_top   = op[0];
      ctrl.a1_top   = 1'b1;
      ctrl.b1_top   = !op[0];
      ctrl.lane1_en = 1'b1;
      ctrl.subtract = op[2];
      ctrl.acc_en   = op[1];
      ctrl.q_en     = !op[2];
    end
  end

  // the two lanes never read the same A half in a dual form
  always_comb begin
    if (op[3]) AST_LANES_SPLIT: assert (ctrl.a0_top != ctrl.a1_top && ctrl.b0_top != ctrl.b1_top); // R3
  end

endmodule

// File: rtl/hmac_lane_mul.sv
module hmac_lane_mul #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0]        a_word,
  input  logic [2*HW-1:0]        b_word,
  input  logic                   a_top,
  input  logic                   b_top,
  input  logic                   en,
  output logic signed [2*HW-1:0] prod
);

  localparam int W = 2 * HW;

  logic signed [HW-1:0] ha;
  logic signed [HW-1:0] hb;
  logic signed [W-1:0]  full;

  assign ha   = a_top ? a_word[W-1:HW] : a_word[HW-1:0];
  assign hb   = b_top ? b_word[W-1:HW] : b_word[HW-1:0];
  assign full = ha * hb;
  assign prod = en ? full : '0;

endmodule

// File: rtl/hmac_combine.sv
module hmac_combine
  import hmac_pkg::*;
#(
  parameter int HW    = 16,
  parameter int ST_W  = 32,
  parameter int Q_BIT = 27
) (
  input  logic signed [2*HW-1:0] p0,
  input  logic signed [2*HW-1:0] p1,
  input  logic [2*HW-1:0]        acc,
  input  hm_ctrl_t               ctrl,
  input  logic [ST_W-1:0]        status_in,
  output logic [2*HW-1:0]        result,
  output logic [ST_W-1:0]        status_nxt
);

  localparam int W   = 2 * HW;
  localparam int EXT = W + 2;

  logic signed [EXT-1:0] e0, e1, ea, e1_term, ea_term, total;
  logic [EXT-W:0]        guard;
  logic                  ovf;

  assign e0      = {{(EXT-W){p0[W-1]}}, p0};
  assign e1      = {{(EXT-W){p1[W-1]}}, p1};
  assign ea      = {{(EXT-W){acc[W-1]}}, acc};
  assign e1_term = ctrl.subtract ? -e1 : e1;
  assign ea_term = ctrl.acc_en ? ea : '0;
  assign total   = e0 + e1_term + ea_term;

  // exact value fits in W signed bits only if guard bits agree with sign
  assign guard = total[EXT-1:W-1];
  assign ovf   = !((guard == '0) || (guard == '1));

  assign result = total[W-1:0];

  always_comb begin
    status_nxt = status_in;
    if (ctrl.q_en && ovf) status_nxt[Q_BIT] = 1'b1;
  end

endmodule

// File: rtl/hmac_out_stage.sv
module hmac_out_stage #(
  parameter int W    = 32,
  parameter int ST_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    res_d,
  input  logic [ST_W-1:0] st_d,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            out_valid,
  output logic [W-1:0]    res_q,
  output logic [ST_W-1:0] st_q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      st_q      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      res_q     <= res_d;
      st_q      <= st_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_q) && $stable(st_q)); // R8

endmodule

// File: rtl/hmac_dual_unit.sv
module hmac_dual_unit
  import hmac_pkg::*;
#(
  parameter int HW    = 16,
  parameter int ST_W  = 32,
  parameter int Q_BIT = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [2*HW-1:0]   in_a,
  input  logic [2*HW-1:0]   in_b,
  input  logic [2*HW-1:0]   in_acc,
  input  logic [ST_W-1:0]   in_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*HW-1:0]   out_result,
  output logic [ST_W-1:0]   out_status
);

  localparam int W = 2 * HW;
  localparam int NLANE = 2;
  localparam logic [ST_W-1:0] QMASK = ST_W'(1) << Q_BIT;

  hm_ctrl_t ctrl;
  logic signed [W-1:0] prod [NLANE];
  logic [W-1:0]        res_d;
  logic [ST_W-1:0]     st_d;
  logic                load;

  hmac_decode u_dec (
    .op   (in_op),
    .ctrl (ctrl)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    hmac_lane_mul #(.HW(HW)) u_mul (
      .a_word (in_a),
      .b_word (in_b),
      .a_top  ((g == 0) ? ctrl.a0_top : ctrl.a1_top),
      .b_top  ((g == 0) ? ctrl.b0_top : ctrl.b1_top),
      .en     ((g == 0) ? 1'b1 : ctrl.lane1_en),
      .prod   (prod[g])
    );
  end

  hmac_combine #(.HW(HW), .ST_W(ST_W), .Q_BIT(Q_BIT)) u_comb (
    .p0         (prod[0]),
    .p1         (prod[1]),
    .acc        (in_acc),
    .ctrl       (ctrl),
    .status_in  (in_status),
    .result     (res_d),
    .status_nxt (st_d)
  );

  assign load = in_valid && in_ready;

  hmac_out_stage #(.W(W), .ST_W(ST_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .res_d     (res_d),
    .st_d      (st_d),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .res_q     (out_result),
    .st_q      (out_status)
  );

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_status[Q_BIT] |=> out_status[Q_BIT]); // R6

  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (out_status | QMASK) == ($past(in_status) | QMASK)); // R5

  AST_QUIET_FORMS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op[3] ? in_op[2] : !in_op[2]) |=> out_status == $past(in_status)); // R6

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8

endmodule

// File: tb/hmac_dual_unit_test.sv
`timescale 1ns/100ps
module hmac_dual_unit_test;
  import hmac_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_acc = '0, in_status = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_result, out_status;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  hmac_dual_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .in_status(in_status), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_status(out_status)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%08h expected=%08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference from the requirements
  task automatic ref_calc(input logic [3:0] op, input logic [31:0] a, b, acc, st,
                          output logic [31:0] r, output logic [31:0] so,
                          output string rtag, output string stag);
    longint ab, at, bb, bt, ac, s, x, y;
    bit qen, ovf;
    ab = longint'($signed(a[15:0]));  at = longint'($signed(a[31:16]));
    bb = longint'($signed(b[15:0]));  bt = longint'($signed(b[31:16]));
    ac = longint'($signed(acc));
    if (!op[3]) begin
      x = op[1] ? at : ab;
      y = op[0] ? bt : bb;
      s = x * y;
      qen = op[2];
      if (op[2]) s = s + ac;
      rtag = op[2] ? "R2" : "R1";
    end else begin
      if (!op[2]) begin
        s = op[0] ? (at * bb + ab * bt) : (at * bt + ab * bb);
        qen = 1'b1;
        rtag = "R3";
      end else begin
        s = op[0] ? (ab * bt - at * bb) : (ab * bb - at * bt);
        qen = 1'b0;
        rtag = "R4";
      end
      if (op[1]) s = s + ac;
    end
    ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    r = s[31:0];
    so = st;
    if (qen && ovf) begin so[27] = 1'b1; stag = "R5"; end
    else stag = "R6";
  endtask

  // cycle model of the output register
  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0, m_st = '0;
  string       m_rtag = "R7", m_stag = "R7";
  logic        m_stall = 1'b0;
  logic [31:0] seen_res = '0, seen_st = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_stall <= 1'b0;
    end else begin
      m_stall <= m_valid && !out_ready;
      if (in_valid && (!m_valid || out_ready)) begin
        logic [31:0] r, so;
        string rt, st;
        ref_calc(in_op, in_a, in_b, in_acc, in_status, r, so, rt, st);
        m_valid <= 1'b1;
        m_res <= r; m_st <= so; m_rtag <= rt; m_stag <= st;
      end else if (out_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R7", "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
      chk("R8", "in_ready", {31'd0, in_ready}, {31'd0, (!m_valid || out_ready)});
      if (m_valid && out_valid) begin
        chk(m_rtag, "result", out_result, m_res);
        chk(m_stag, "status", out_status, m_st);
        if (m_stall) begin
          chk("R8", "held result", out_result, seen_res);
          chk("R8", "held status", out_status, seen_st);
        end
        seen_res = out_result;
        seen_st  = out_status;
      end
    end
  end

  task automatic send(logic [3:0] op, logic [31:0] a, b, acc, st);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_acc = acc; in_status = st;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] pick_half();
    case ($urandom_range(0, 4))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9", "reset in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 single products, each half pairing
    send(OP_MUL_BB, 32'h0003_FFFE, 32'h0005_0007, 32'h1234_5678, 32'h0000_0000);
    send(OP_MUL_TT, 32'h8000_0001, 32'h8000_0001, 32'h0,         32'h0000_0000);
    send(OP_MUL_BT, 32'h1234_FFFF, 32'h0002_0010, 32'h0,         32'hA000_0003);
    send(OP_MUL_TB, 32'h1234_FFFF, 32'h0002_0010, 32'h0,         32'h0);
    // R2 accumulate, positive and negative overflow with R5 flag
    send(OP_MAC_BB, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 32'hF000_0001);
    send(OP_MAC_TT, 32'h7FFF_0000, 32'h8000_0000, 32'h8000_0000, 32'h0);
    send(OP_MAC_TB, 32'h0010_0000, 32'h0000_FFFD, 32'hFFFF_FFF0, 32'h0);
    // R3 dual add: no-acc overflow at exactly 2^31
    send(OP_DADD,     32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0);
    send(OP_DADDX,    32'h0002_0003, 32'h0005_0007, 32'h0, 32'h0);
    send(OP_DADD_ACC, 32'h8000_8000, 32'h7FFF_7FFF, 32'h8000_0000, 32'h0);
    send(OP_DADDX_ACC,32'h0002_0003, 32'h0005_0007, 32'h0000_0064, 32'h0);
    // R4 dual subtract; overflow leaves status alone (R6)
    send(OP_DSUB,     32'h0002_0003, 32'h0005_0007, 32'h0, 32'h0);
    send(OP_DSUBX,    32'h0002_0003, 32'h0005_0007, 32'h0, 32'h0);
    send(OP_DSUB_ACC, 32'h8000_8000, 32'h7FFF_8000, 32'h7FFF_FFFF, 32'h0000_0000);
    send(OP_DSUBX_ACC,32'h0002_0003, 32'h0005_0007, 32'hFFFF_FFFF, 32'h0);
    // R6 sticky flag survives a non-overflowing op
    send(OP_MAC_BB,   32'h0000_0002, 32'h0000_0003, 32'h0, 32'h0800_0000);
    send(OP_MUL_BB,   32'h0000_0002, 32'h0000_0003, 32'h0, 32'h0800_0000);

    // random traffic with back-pressure, biased toward extreme halves
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      in_valid  = ($urandom_range(0, 3) != 0);
      in_op     = 4'($urandom);
      in_a      = {pick_half(), pick_half()};
      in_b      = {pick_half(), pick_half()};
      in_acc    = ($urandom_range(0, 2) == 0) ? 32'h7FFF_FFFF :
                  ($urandom_range(0, 1) == 0) ? 32'h8000_0000 : $urandom;
      in_status = $urandom;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule